// File: doc/BRIEF.md
# Async transmit hang monitor

This block sits beside the asynchronous transmit and receive FIFOs of a serial-bus link layer. It watches each outgoing packet for signs that the remote node has locked up. Software loads every quadlet of a packet except the last one, and then raises a request. The monitor answers with a one-cycle pulse that clears the pending transmit-ready and receive-data flags. After that it issues the final-quadlet write strobe, either at once or, in the cycle-aligned mode, only after the next isochronous cycle event. This gives at most one asynchronous packet per cycle.

Once the final quadlet is written, the monitor watches which event comes first. A transmit-complete (acknowledge received) ends the transaction as a success. A received packet that arrives strictly before it means the acknowledge was lost and the node is hung. In that case the monitor sets a sticky hang flag and pulses a receiver reset for one cycle. The queued packet stays in the FIFO and is never rewritten, so the monitor keeps watching for the completion of the link's own retry. A programmable watchdog window reports a missing acknowledge when neither event arrives.

Top module: `async_hang_monitor`

## Requirements
- R1: After reset, flag_clr, fq_wr, rx_reset, tx_ok, hang_flag and ack_to are all 0 and the monitor is idle.
- R2: A fq_req sampled while idle produces a one-cycle flag_clr pulse in the next cycle. With align_en=0, fq_wr pulses for one cycle in the cycle right after flag_clr, and exactly once per transaction.
- R3: With align_en=1, fq_wr is held back after flag_clr until a cyc_evt is sampled. fq_wr then pulses for one cycle in the cycle after that.
- R4: While watching, a sampled tx_done gives a one-cycle tx_ok pulse in the next cycle and returns the monitor to idle. This also holds when rx_pkt is sampled in the same cycle, and then there is no hang.
- R5: While watching, an rx_pkt sampled without tx_done sets hang_flag and gives a one-cycle rx_reset pulse in the next cycle. The monitor keeps watching without a new fq_wr, so each further rx_pkt gives another pulse and a later tx_done still gives tx_ok.
- R6: If neither event is sampled during tmo_lim consecutive watching cycles, ack_to is set and the monitor returns to idle. tmo_lim=0 disables the window.
- R7: hang_flag and ack_to are sticky and are cleared by clr_flags. A set in the same cycle as clr_flags wins.
- R8: fq_req is ignored while a transaction is in progress, and tx_done and rx_pkt are ignored while idle. None of these produces a pulse or a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fq_req | input | 1 | Software request to write the final quadlet |
| align_en | input | 1 | 1 = hold the final write until a cycle event |
| cyc_evt | input | 1 | Isochronous cycle-start or cycle-done strobe |
| tx_done | input | 1 | Transmit complete with acknowledge received |
| rx_pkt | input | 1 | Packet received into the receive FIFO |
| clr_flags | input | 1 | Clears hang_flag and ack_to |
| tmo_lim | input | TW | Watch window in cycles, 0 = no limit |
| flag_clr | output | 1 | Pulse: clear pending transmit-ready and receive-data flags |
| fq_wr | output | 1 | Pulse: write the final quadlet into the transmit FIFO |
| rx_reset | output | 1 | Pulse: receiver reset |
| tx_ok | output | 1 | Pulse: transaction completed normally |
| hang_flag | output | 1 | Sticky: remote hang detected |
| ack_to | output | 1 | Sticky: acknowledge missing within the window |

## Verification
The hardest case to reach is a hang followed by a retry. The receive event has to land in a watching cycle before any completion, possibly more than once, and the bench then has to show that no second final write appears and that the later completion is still accepted. The vector table places the receive and completion strobes at chosen distances after the observed fq_wr pulse, in both the immediate and the cycle-aligned mode. It also puts both strobes in one cycle to pin down the tie case. Directed tests count the exact cycle at which the window expires, and they collide a new hang with clr_flags.

// File: rtl/ahm_pkg.sv
package ahm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLR,
    ST_HOLD,
    ST_WR,
    ST_WATCH
  } ahm_state_t;

  // Window expiry: last allowed cycle reached, limit 0 means unlimited.
  function automatic logic window_hit(input logic [31:0] cnt, input logic [31:0] lim);
    return (lim != 32'd0) && (cnt == lim - 32'd1);
  endfunction

endpackage

// File: rtl/ahm_timer.sv
module ahm_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [TW-1:0] lim,
  output logic          expire
);
  import ahm_pkg::*;

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || restart) cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  assign expire = run && window_hit(32'(cnt), 32'(lim));

  // Counter never passes the window while the limit is held.
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && lim != '0 && $stable(lim)) |-> (cnt < lim));

endmodule

// File: rtl/ahm_sticky.sv
module ahm_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr) |=> $stable(q));
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);

endmodule

// File: rtl/ahm_seq.sv
module ahm_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic fq_req,
  input  logic align_en,
  input  logic cyc_evt,
  input  logic tx_done,
  input  logic rx_pkt,
  input  logic expire,
  output logic flag_clr,
  output logic fq_wr,
  output logic held,
  output logic watching,
  output logic hang_evt,
  output logic ok_evt,
  output logic to_evt,
  output logic rx_reset,
  output logic tx_ok
);
  import ahm_pkg::*;

  ahm_state_t state_q, state_d;

  assign flag_clr = (state_q == ST_CLR);
  assign fq_wr    = (state_q == ST_WR);
  assign held     = (state_q == ST_HOLD);
  assign watching = (state_q == ST_WATCH);

  // Event decode while the final quadlet is outstanding.
  assign ok_evt   = watching && tx_done;
  assign hang_evt = watching && rx_pkt && !tx_done;
  assign to_evt   = watching && !tx_done && !rx_pkt && expire;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (fq_req) state_d = ST_CLR;
      ST_CLR:   state_d = align_en ? ST_HOLD : ST_WR;
      ST_HOLD:  if (cyc_evt) state_d = ST_WR;
      ST_WR:    state_d = ST_WATCH;
      ST_WATCH: if (ok_evt || to_evt) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      rx_reset <= 1'b0;
      tx_ok    <= 1'b0;
    end else begin
      state_q  <= state_d;
      rx_reset <= hang_evt;
      tx_ok    <= ok_evt;
    end
  end

  assert_single_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fq_wr |=> !fq_wr);
  assert_clr_before_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fq_wr |-> ($past(flag_clr) || $past(held)));
  assert_hold_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fq_wr && $past(held)) |-> $past(cyc_evt));
  assert_ok_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ok |-> ($past(tx_done) && !watching));
  assert_reset_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset |-> ($past(rx_pkt) && !$past(tx_done) && watching));
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(state_q == ST_IDLE) |-> (!rx_reset && !tx_ok));
  assert_pulse_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flag_clr, fq_wr, held, watching}));

endmodule

// File: rtl/async_hang_monitor.sv
module async_hang_monitor #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fq_req,
  input  logic          align_en,
  input  logic          cyc_evt,
  input  logic          tx_done,
  input  logic          rx_pkt,
  input  logic          clr_flags,
  input  logic [TW-1:0] tmo_lim,
  output logic          flag_clr,
  output logic          fq_wr,
  output logic          rx_reset,
  output logic          tx_ok,
  output logic          hang_flag,
  output logic          ack_to
);
  localparam int NFLAG = 2;

  logic held, watching, hang_evt, ok_evt, to_evt, expire;
  logic [NFLAG-1:0] flag_set, flag_q;

  ahm_seq u_seq (
    .clk(clk), .rst_n(rst_n), .fq_req(fq_req), .align_en(align_en),
    .cyc_evt(cyc_evt), .tx_done(tx_done), .rx_pkt(rx_pkt), .expire(expire),
    .flag_clr(flag_clr), .fq_wr(fq_wr), .held(held), .watching(watching),
    .hang_evt(hang_evt), .ok_evt(ok_evt), .to_evt(to_evt),
    .rx_reset(rx_reset), .tx_ok(tx_ok)
  );

  ahm_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(watching), .restart(hang_evt),
    .lim(tmo_lim), .expire(expire)
  );

  assign flag_set = {to_evt, hang_evt};

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    ahm_sticky u_flag (
      .clk(clk), .rst_n(rst_n), .set(flag_set[g]), .clr(clr_flags), .q(flag_q[g])
    );
  end

  assign hang_flag = flag_q[0];
  assign ack_to    = flag_q[1];

  assert_hang_pairs_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset |-> hang_flag);
  assert_timeout_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_to) |-> !watching);

endmodule

// File: tb/async_hang_monitor_bench.sv
`timescale 1ns/1ps
module async_hang_monitor_bench;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fq_req = 0, align_en = 0, cyc_evt = 0, tx_done = 0, rx_pkt = 0, clr_flags = 0;
  logic [TW-1:0] tmo_lim = 16'd50;
  logic flag_clr, fq_wr, rx_reset, tx_ok, hang_flag, ack_to;

  async_hang_monitor #(.TW(TW)) u_async_hang_monitor (
    .clk(clk), .rst_n(rst_n), .fq_req(fq_req), .align_en(align_en),
    .cyc_evt(cyc_evt), .tx_done(tx_done), .rx_pkt(rx_pkt), .clr_flags(clr_flags),
    .tmo_lim(tmo_lim), .flag_clr(flag_clr), .fq_wr(fq_wr), .rx_reset(rx_reset),
    .tx_ok(tx_ok), .hang_flag(hang_flag), .ack_to(ack_to)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int n_wr = 0, n_rst = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (fq_wr)    n_wr++;
    if (rx_reset) n_rst++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Mask: {clr_flags, fq_req, cyc_evt, rx_pkt, tx_done}; driven at a negedge,
  // held across one posedge, released at the next negedge.
  task automatic pulse(input logic [4:0] m);
    {clr_flags, fq_req, cyc_evt, rx_pkt, tx_done} = m;
    @(negedge clk);
    {clr_flags, fq_req, cyc_evt, rx_pkt, tx_done} = 5'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Starts a transaction; returns at the negedge where fq_wr is high.
  task automatic start_txn(input bit al, input string tag);
    align_en = al;
    pulse(5'b01000);
    chk({tag, " flag_clr"}, int'(flag_clr), 1);
    chk({tag, " no early fq_wr"}, int'(fq_wr), 0);
    if (al) begin
      idle(3);
      chk({tag, " R3 held"}, int'(fq_wr), 0);
      pulse(5'b00100);
      chk({tag, " R3 fq_wr after cyc_evt"}, int'(fq_wr), 1);
    end else begin
      idle(1);
      chk({tag, " R2 fq_wr"}, int'(fq_wr), 1);
    end
  endtask

  // Table entry: {align, kind[1:0], gap[4:0]}
  // kind 0: tx only, 1: rx then tx, 2: rx and tx same cycle, 3: rx, rx, tx
  localparam int NVEC = 8;
  localparam logic [7:0] VEC [NVEC] = '{
    {1'b0, 2'd0, 5'd0}, {1'b0, 2'd1, 5'd2}, {1'b0, 2'd2, 5'd1}, {1'b0, 2'd3, 5'd3},
    {1'b1, 2'd0, 5'd4}, {1'b1, 2'd1, 5'd0}, {1'b1, 2'd2, 5'd5}, {1'b1, 2'd3, 5'd1}
  };

  function automatic int exp_resets(input logic [1:0] k);
    return (k == 2'd1) ? 1 : (k == 2'd3) ? 2 : 0;
  endfunction

  initial begin
    idle(3);
    chk("R1 flag_clr", int'(flag_clr), 0);
    chk("R1 fq_wr", int'(fq_wr), 0);
    chk("R1 rx_reset", int'(rx_reset), 0);
    chk("R1 tx_ok", int'(tx_ok), 0);
    chk("R1 hang_flag", int'(hang_flag), 0);
    chk("R1 ack_to", int'(ack_to), 0);
    rst_n = 1'b1;
    idle(2);

    // R8: completion and receive strobes while idle
    pulse(5'b00001);
    chk("R8 idle tx_done", int'(tx_ok), 0);
    pulse(5'b00010);
    chk("R8 idle rx_pkt", int'(rx_reset), 0);
    chk("R8 idle hang_flag", int'(hang_flag), 0);

    for (int i = 0; i < NVEC; i++) begin
      logic al;
      logic [1:0] kind;
      int gap, wr0, rst0;
      {al, kind} = VEC[i][7:5];
      gap = int'(VEC[i][4:0]);
      wr0 = n_wr;
      rst0 = n_rst;
      start_txn(al, $sformatf("vec%0d", i));
      idle(1 + gap);
      if (kind == 2'd2) begin
        pulse(5'b00011);
        chk($sformatf("vec%0d R4 tie tx_ok", i), int'(tx_ok), 1);
        chk($sformatf("vec%0d R4 tie rx_reset", i), int'(rx_reset), 0);
      end else begin
        for (int r = 0; r < exp_resets(kind); r++) begin
          pulse(5'b00010);
          chk($sformatf("vec%0d R5 rx_reset", i), int'(rx_reset), 1);
          chk($sformatf("vec%0d R5 hang_flag", i), int'(hang_flag), 1);
          idle(gap);
        end
        pulse(5'b00001);
        chk($sformatf("vec%0d R4 tx_ok", i), int'(tx_ok), 1);
      end
      idle(1);
      chk($sformatf("vec%0d R4 tx_ok single", i), int'(tx_ok), 0);
      chk($sformatf("vec%0d R5 resets", i), n_rst - rst0, exp_resets(kind));
      chk($sformatf("vec%0d R5 one write", i), n_wr - wr0, 1);
      chk($sformatf("vec%0d R5 hang_flag", i), int'(hang_flag), (kind == 2'd1 || kind == 2'd3) ? 1 : 0);
      pulse(5'b10000);
      chk($sformatf("vec%0d R7 cleared", i), int'(hang_flag), 0);
      idle(2);
    end

    // R8: fq_req while a transaction is watching
    begin
      int wr0;
      wr0 = n_wr;
      start_txn(1'b0, "busy");
      idle(2);
      pulse(5'b01000);
      chk("R8 busy flag_clr", int'(flag_clr), 0);
      idle(2);
      chk("R8 busy fq_wr", int'(fq_wr), 0);
      pulse(5'b00001);
      chk("R8 busy tx_ok", int'(tx_ok), 1);
      chk("R8 busy writes", n_wr - wr0, 1);
      idle(2);
    end

    // R6: exact window with limit 6
    tmo_lim = 16'd6;
    start_txn(1'b0, "tmo");
    idle(6);
    chk("R6 not yet", int'(ack_to), 0);
    idle(1);
    chk("R6 ack_to set", int'(ack_to), 1);
    pulse(5'b00010);
    chk("R6 idle after timeout", int'(rx_reset), 0);
    idle(3);
    chk("R7 ack_to sticky", int'(ack_to), 1);
    pulse(5'b10000);
    chk("R7 ack_to cleared", int'(ack_to), 0);

    // R6: completion on the last cycle inside the window
    start_txn(1'b0, "tmo_edge");
    idle(6);
    pulse(5'b00001);
    chk("R6 last-cycle tx_ok", int'(tx_ok), 1);
    chk("R6 last-cycle no ack_to", int'(ack_to), 0);

    // R6: limit 0 disables the window
    tmo_lim = 16'd0;
    start_txn(1'b0, "nolim");
    idle(40);
    chk("R6 disabled", int'(ack_to), 0);
    pulse(5'b00001);
    chk("R6 disabled tx_ok", int'(tx_ok), 1);

    // R7: hang collides with clr_flags, set wins
    tmo_lim = 16'd50;
    start_txn(1'b0, "collide");
    idle(1);
    pulse(5'b10010);
    chk("R7 set wins", int'(hang_flag), 1);
    pulse(5'b00001);
    pulse(5'b10000);
    chk("R7 cleared after", int'(hang_flag), 0);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual expired expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule